// File: doc/BRIEF.md
# Square-Wave Dither Source with Synchronous Gain Detector

This block excites a closed control loop with a small square wave and measures how the loop's plant answers. It produces one dither sample per clock. The caller adds that sample to its controller output. The block also takes back one error sample per clock from the input side of the loop. Each error sample is multiplied by +1 or −1, following the polarity of the square wave. Before that multiplication the square-wave polarity is delayed by a programmable number of samples, which accounts for the latency of the loop.

The products are summed over a whole number of dither periods. At the end of each window the sum is loaded into a result register and a one-cycle ready pulse is raised. The running sum then starts again from zero. The result is proportional to the plant gain times the dither amplitude and the window length, and it carries the gain's sign. Because the block keeps running during closed-loop operation, this measurement stays current. Software turns the result into physical units.

Amplitude, half-period, periods per window and reference delay are static inputs. They are changed only while the dither is disabled.

Top module: `dither_lockin`

## Requirements
- R1: While reset is high and in the cycle after it, `dith_out`, `result` and `ready` are all zero.
- R2: From the first clock edge sampled with `en` low, `dith_out` is exactly zero. The partial sum and the window position are discarded.
- R3: Call the first edge sampled with `en` high edge 0. After edge k, `dith_out` equals +`amp` when floor(k / `half_per`) is even and −`amp` when it is odd. `amp` is a magnitude no larger than 2^(DW−1)−1, and `half_per` is at least 1.
- R4: With D = `ref_dly`, the error sample taken at edge k is multiplied by the sign of the dither sample produced at edge k−1−D. Edges for which that sample does not yet exist are not accumulated. A delay that is off by one half-period inverts the sign of every contribution.
- R5: A window holds 2·`half_per`·`n_per` accumulated samples. The first window ends at edge D + 2·`half_per`·`n_per`, and each later window ends that many edges after the previous one.
- R6: At the end of each window, the window's sum is loaded into `result` and `ready` is high for exactly one cycle. The next window then starts from zero. For a plant err = g·dither with matched delay, each window gives g·`amp`·2·`half_per`·`n_per`, including the sign of g.
- R7: While `en` is low, `result` keeps its last value, `ready` stays low, and `err_in` has no effect.
- R8: Re-enabling after a partial window starts a fresh window. The earlier partial sum does not appear in any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Dither and detection enable |
| amp | input | DW | Dither magnitude |
| half_per | input | HPW | Samples per half period |
| n_per | input | NPW | Dither periods per window |
| ref_dly | input | DLYW | Reference delay in samples |
| err_in | input | DW | Signed error sample from the loop input |
| dith_out | output | DW | Signed dither sample, registered |
| result | output | ACCW | Signed sum of the last completed window |
| ready | output | 1 | One-cycle pulse when `result` updates |

## Verification
A bench plant returns the dither multiplied by a signed gain after a chosen latency. The runs use the following patterns:
- A positive gain with matched delay confirms the magnitude of the sum and when each window ends.
- A negative gain with a longer latency shows that the sign is kept and that the delay lines the reference up.
- A delay that is wrong by exactly one half-period must give a negative result, and its first window must be a shortened one. This separates correct delay handling from simply ignoring the delay.
- Full-scale amplitude with a one-sample half-period tests the widest values and the fastest polarity changes.
- Disabling the block in the middle of a window, with noise forced on the error input, separates holding the result from leaking a partial sum into it.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic {PH_POS = 1'b0, PH_NEG = 1'b1} dl_phase_e;
endpackage

// File: rtl/dl_sqgen.sv
module dl_sqgen
  import dl_pkg::*;
#(
  parameter int DW  = 16,
  parameter int HPW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [DW-1:0]        amp,
  input  logic [HPW-1:0]       hp_eff,
  output logic signed [DW-1:0] dith_out,
  output dl_phase_e            ph_now
);
  logic [HPW-1:0] cnt;
  dl_phase_e      ph;
  logic signed [DW-1:0] amp_s;
  logic           last;

  assign amp_s  = signed'(amp);
  assign last   = (cnt >= hp_eff - HPW'(1));
  assign ph_now = ph;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt      <= '0;
      ph       <= PH_POS;
      dith_out <= '0;
    end else begin
      dith_out <= (ph == PH_NEG) ? -amp_s : amp_s;
      if (last) begin
        cnt <= '0;
        ph  <= (ph == PH_POS) ? PH_NEG : PH_POS;
      end else begin
        cnt <= cnt + HPW'(1);
      end
    end
  end

  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> dith_out == '0); // R2
  AST_DITH_LEVELS: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |-> (dith_out == $past(amp_s) || dith_out == -$past(amp_s))); // R3
endmodule

// File: rtl/dl_refdelay.sv
module dl_refdelay #(
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            sign_in,
  input  logic [DLYW-1:0] sel,
  output logic            ref_neg,
  output logic            ref_ok
);
  localparam int DEPTH = 1 << DLYW;
  logic [DEPTH-1:0] sgn;
  logic [DEPTH-1:0] vld;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          sgn[0] <= 1'b0;
          vld[0] <= 1'b0;
        end else begin
          sgn[0] <= sign_in;
          vld[0] <= 1'b1;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          sgn[i] <= 1'b0;
          vld[i] <= 1'b0;
        end else begin
          sgn[i] <= sgn[i-1];
          vld[i] <= vld[i-1];
        end
      end
    end
  end

  assign ref_neg = sgn[sel];
  assign ref_ok  = vld[sel];
endmodule

// File: rtl/dl_accum.sv
module dl_accum #(
  parameter int DW   = 16,
  parameter int ACCW = 38,
  parameter int WLW  = 21
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   ref_neg,
  input  logic                   ref_ok,
  input  logic signed [DW-1:0]   err_in,
  input  logic [WLW-1:0]         win_len,
  output logic signed [ACCW-1:0] result,
  output logic                   ready
);
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] ext;
  logic signed [ACCW-1:0] term;
  logic [WLW-1:0]         wcnt;
  logic                   win_end;

  assign ext     = {{(ACCW-DW){err_in[DW-1]}}, err_in};
  assign term    = ref_neg ? -ext : ext;
  assign win_end = (wcnt == win_len - WLW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      wcnt   <= '0;
      result <= '0;
      ready  <= 1'b0;
    end else if (!en) begin
      acc   <= '0;
      wcnt  <= '0;
      ready <= 1'b0;
    end else if (ref_ok) begin
      if (win_end) begin
        result <= acc + term;
        acc    <= '0;
        wcnt   <= '0;
        ready  <= 1'b1;
      end else begin
        acc   <= acc + term;
        wcnt  <= wcnt + WLW'(1);
        ready <= 1'b0;
      end
    end else begin
      ready <= 1'b0;
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !ready |-> $stable(result)); // R7
endmodule

// File: rtl/dither_lockin.sv
module dither_lockin
  import dl_pkg::*;
#(
  parameter int DW   = 16,
  parameter int HPW  = 12,
  parameter int NPW  = 8,
  parameter int DLYW = 4,
  parameter int ACCW = DW + HPW + NPW + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [DW-1:0]          amp,
  input  logic [HPW-1:0]         half_per,
  input  logic [NPW-1:0]         n_per,
  input  logic [DLYW-1:0]        ref_dly,
  input  logic signed [DW-1:0]   err_in,
  output logic signed [DW-1:0]   dith_out,
  output logic signed [ACCW-1:0] result,
  output logic                   ready
);
  localparam int WLW = HPW + NPW + 1;

  logic [HPW-1:0] hp_eff;
  logic [NPW-1:0] np_eff;
  logic [WLW-1:0] win_len;
  dl_phase_e      ph_now;
  logic           ref_neg;
  logic           ref_ok;

  assign hp_eff  = (half_per == '0) ? HPW'(1) : half_per;
  assign np_eff  = (n_per == '0) ? NPW'(1) : n_per;
  assign win_len = (WLW'(hp_eff) * WLW'(np_eff)) << 1;

  dl_sqgen #(.DW(DW), .HPW(HPW)) u_gen (
    .clk(clk), .rst(rst), .en(en), .amp(amp), .hp_eff(hp_eff),
    .dith_out(dith_out), .ph_now(ph_now)
  );

  dl_refdelay #(.DLYW(DLYW)) u_dly (
    .clk(clk), .rst(rst), .en(en), .sign_in(ph_now == PH_NEG),
    .sel(ref_dly), .ref_neg(ref_neg), .ref_ok(ref_ok)
  );

  dl_accum #(.DW(DW), .ACCW(ACCW), .WLW(WLW)) u_acc (
    .clk(clk), .rst(rst), .en(en), .ref_neg(ref_neg), .ref_ok(ref_ok),
    .err_in(err_in), .win_len(win_len), .result(result), .ready(ready)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (dith_out == '0 && !ready)); // R1
endmodule

// File: tb/dither_lockin_tb.sv
module dither_lockin_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [15:0] amp = '0;
  logic [11:0] half_per = 12'd1;
  logic [7:0]  n_per = 8'd1;
  logic [3:0]  ref_dly = '0;
  logic signed [15:0] err_in;
  logic signed [15:0] dith_out;
  logic signed [37:0] result;
  logic ready;

  int checks = 0;
  int fails = 0;
  int gain = 0;
  int lat = 0;
  bit noise = 1'b0;
  bit chk_dith = 1'b0;
  int hp_i = 1;
  int amp_i = 0;
  int en_edges = 0;
  int pipe [0:19];

  typedef struct {longint val; int cnt; string tag;} item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  dither_lockin u_dut (
    .clk(clk), .rst(rst), .en(en), .amp(amp), .half_per(half_per),
    .n_per(n_per), .ref_dly(ref_dly), .err_in(err_in),
    .dith_out(dith_out), .result(result), .ready(ready)
  );

  initial for (int i = 0; i < 20; i++) pipe[i] = 0;

  always @(negedge clk) begin
    for (int j = 19; j > 0; j--) pipe[j] = pipe[j-1];
    pipe[0] = int'(dith_out);
  end

  always_comb err_in = noise ? 16'sd777 : 16'(gain * pipe[lat]);

  always @(posedge clk) en_edges <= en ? en_edges + 1 : 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop plus waveform check
  always @(negedge clk) begin
    if (!rst && ready) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R7 unexpected ready", longint'(result), 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(longint'(result) == it.val, it.tag, longint'(result), it.val);
        check(en_edges == it.cnt, "R5 window end edge", en_edges, it.cnt);
      end
    end
    if (!rst && en && chk_dith && en_edges > 0) begin
      int k;
      int e;
      k = en_edges - 1;
      e = (((k / hp_i) % 2) == 0) ? amp_i : -amp_i;
      check(int'(dith_out) == e, "R3 dither level", dith_out, e);
    end
  end

  task automatic setup(input int a, input int h, input int n, input int g, input int l, input int d);
    @(negedge clk); #1;
    en = 1'b0; noise = 1'b0;
    amp = 16'(a); half_per = 12'(h); n_per = 8'(n); ref_dly = 4'(d);
    gain = g; lat = l; hp_i = h; amp_i = a;
    repeat (24) @(negedge clk);
    #1;
  endtask

  task automatic run(input int nwin, input int d, input int w, input longint first, input longint rest, input string tag);
    for (int i = 0; i < nwin; i++) begin
      item_t it;
      it.val = (i == 0) ? first : rest;
      it.cnt = d + w * (i + 1) + 1;
      it.tag = tag;
      sbq.push_back(it);
    end
    en = 1'b1;
    while (sbq.size() > 0) begin
      @(negedge clk); #1;
    end
    en = 1'b0;
    chk_dith = 1'b0;
  endtask

  task automatic hold_check();
    longint held;
    @(negedge clk); #1;
    en = 1'b0;
    held = longint'(result);
    noise = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(dith_out == 0, "R2 zero when disabled", dith_out, 0);
    end
    check(longint'(result) == held, "R7 result held", longint'(result), held);
    #1 noise = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dith_out == 0, "R1 dith reset", dith_out, 0);
    check(result == 0, "R1 result reset", result, 0);
    check(ready == 0, "R1 ready reset", ready, 0);
    #1 rst = 1'b0;
    @(negedge clk);
    check(dith_out == 0 && !ready, "R1 after reset", dith_out, 0);

    // R6: positive gain, matched delay, dither waveform checked (R3)
    setup(100, 3, 2, 2, 0, 0);
    chk_dith = 1'b1;
    run(3, 0, 12, 2400, 2400, "R6 positive gain");
    hold_check();

    // R6/R4: negative gain, delay compensates latency of 4
    setup(50, 5, 1, -3, 4, 4);
    run(3, 4, 10, -1500, -1500, "R6 negative gain");
    hold_check();

    // R4: delay off by one half period -> inverted, short first window
    setup(20, 4, 1, 1, 6, 2);
    run(3, 2, 8, -80, -160, "R4 half-period mismatch");
    hold_check();

    // R8: abort mid-window, then a fresh window
    setup(100, 3, 2, 2, 0, 0);
    en = 1'b1;
    repeat (8) @(negedge clk);
    hold_check();
    setup(100, 3, 2, 2, 0, 0);
    run(2, 0, 12, 2400, 2400, "R8 fresh window after abort");

    // R3/R6: full-scale amplitude, one-sample half period
    setup(32767, 1, 1, 1, 0, 0);
    chk_dith = 1'b1;
    run(3, 0, 2, 65534, 65534, "R6 full scale");
    setup(32767, 1, 3, -1, 0, 0);
    chk_dith = 1'b1;
    run(2, 0, 6, -196602, -196602, "R6 full scale negative");
    hold_check();

    check(sbq.size() == 0, "R5 all windows seen", sbq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", sbq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule